// File: doc/BRIEF.md
# Interrupt-Latched Elapsed Timer

A 24-bit elapsed-time counter that sits in a memory-mapped register file. It advances once for each pulse of a one-cycle strobe that arrives every 10 microseconds, so each count stands for 0.01 ms. Software controls it and reads it through one 32-bit register on a single-cycle command port. Bit 31 of that register is the run bit and the low bits hold the count.

The run bit clears itself in two cases. The first is when the count reaches its all-ones value. The second is when any interrupt source asserts while its enable is also set. In both cases the count at that instant stays frozen, so software can read how much time passed before the event.

A typical use is to measure a response time. Software starts the timer, enables the interrupt it is waiting for, and later reads the time at which that interrupt arrived.

Top module: `elapsed_timer`

## Requirements
- R1: After reset the run bit is 0, the count is 0, and a read of the register returns 0.
- R2: A write with bit 31 set clears the count to 0 and sets the run bit. A write command uses the read code with bit 7 set; the default read code is 0x27, so the default write code is 0xA7.
- R3: While the timer is running, the count rises by exactly one on each cycle in which tick_10us is high. It does not change on cycles in which tick_10us is low.
- R4: A write with bit 31 clear stops the timer and keeps the current count. Ticks that arrive later leave the count unchanged.
- R5: When a tick takes the count to all ones, the run bit clears in the same cycle. Further ticks leave the count at all ones.
- R6: While the timer is running, if any bit position has both irq_status and irq_enable high, the run bit clears and the count is frozen. A status bit whose enable is low has no effect.
- R7: If a write with bit 31 set arrives in the same cycle as an interrupt stop, the write wins: the count restarts at 0 and the run bit stays set.
- R8: An interrupt stop takes priority over a tick in the same cycle, so the count does not advance in that cycle.
- R9: A read (cmd_valid high with the read code) returns the run bit in bit 31, zeros in bits 30 down to the counter width, and the count in the low bits. Reserved bits read as 0 even when a write set them. With any other code, or with cmd_valid low, rd_data is 0 and the command has no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_10us | input | 1 | One-cycle count enable, pulsed every 10 us |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Register command code; bit 7 set selects a write |
| wr_data | input | 32 | Write data |
| irq_status | input | 8 | Interrupt source status bits |
| irq_enable | input | 8 | Per-source enable bits |
| rd_data | output | 32 | Read data, valid in the same cycle as a read command |
| running | output | 1 | Current value of the run bit |

## Verification
The bench drives the counter to its all-ones limit and checks that it stays there. A design with an off-by-one limit would either wrap to zero or stop one count early. It fires an interrupt in the same cycle as a restart write and in the same cycle as a tick. Getting the priority wrong would either leave the timer halted after the write or report a count one higher than the true stop time. It also sends status bits that have no matching enable, and commands that use a neighbouring code. A design that ignored the mask or decoded the code loosely would then stop or change the timer when it should not.

// File: rtl/elapsed_timer.sv
module elapsed_timer #(
  parameter int          CNT_W   = 24,
  parameter int          IRQ_W   = 8,
  parameter int          DATA_W  = 32,
  parameter logic [7:0]  RD_CODE = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_10us,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IRQ_W-1:0]  irq_status,
  input  logic [IRQ_W-1:0]  irq_enable,
  output logic [DATA_W-1:0] rd_data,
  output logic              running
);
  localparam logic [7:0]       WR_CODE  = RD_CODE | 8'h80;
  localparam int               RUN_BIT  = DATA_W - 1;
  localparam int               RSV_W    = DATA_W - 1 - CNT_W;
  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  wire wr_hit  = cmd_valid && (cmd_code == WR_CODE);
  wire rd_hit  = cmd_valid && (cmd_code == RD_CODE);
  wire irq_hit = |(irq_status & irq_enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (wr_hit) begin
      if (wr_data[RUN_BIT]) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        run_q <= 1'b0;
      end
    end else if (run_q && irq_hit) begin
      run_q <= 1'b0;
    end else if (run_q && tick_10us) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) run_q <= 1'b0;
    end
  end

  assign rd_data = rd_hit ? {run_q, {RSV_W{1'b0}}, cnt_q} : '0;
  assign running = run_q;
endmodule

module elapsed_timer_chk #(
  parameter int         CNT_W   = 24,
  parameter int         IRQ_W   = 8,
  parameter int         DATA_W  = 32,
  parameter logic [7:0] RD_CODE = 8'h27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_10us,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic [DATA_W-1:0] wr_data,
  input logic [IRQ_W-1:0]  irq_status,
  input logic [IRQ_W-1:0]  irq_enable,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [7:0]       WR_C = RD_CODE | 8'h80;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic wr1, wr0, irq;
  assign wr1 = cmd_valid && cmd_code == WR_C && wr_data[DATA_W-1];
  assign wr0 = cmd_valid && cmd_code == WR_C && !wr_data[DATA_W-1];
  assign irq = |(irq_status & irq_enable);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr1 |=> (run_q && cnt_q == '0));
  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> (!run_q && cnt_q == $past(cnt_q)));
  a_r6_irq_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr1 && !wr0 && run_q && irq) |=> (!run_q && $stable(cnt_q)));
  a_r5_never_run_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != MAXV));
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr1 && !wr0 && run_q && !irq && tick_10us) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr1 && !(run_q && tick_10us)) |=> $stable(cnt_q));
endmodule

bind elapsed_timer elapsed_timer_chk #(
  .CNT_W(CNT_W), .IRQ_W(IRQ_W), .DATA_W(DATA_W), .RD_CODE(RD_CODE)
) i_elapsed_timer_chk (
  .clk(clk), .rst_n(rst_n), .tick_10us(tick_10us), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .wr_data(wr_data), .irq_status(irq_status),
  .irq_enable(irq_enable), .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/test_elapsed_timer.sv
module test_elapsed_timer;
  localparam int         CW  = 8;
  localparam logic [7:0] RDC = 8'h27;
  localparam logic [7:0] WRC = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_10us = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] irq_status = '0;
  logic [7:0] irq_enable = '0;
  logic [31:0] rd_data;
  logic running;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  elapsed_timer #(.CNT_W(CW)) i_elapsed_timer (
    .clk(clk), .rst_n(rst_n), .tick_10us(tick_10us), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .wr_data(wr_data), .irq_status(irq_status),
    .irq_enable(irq_enable), .rd_data(rd_data), .running(running)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    #1 v = rd_data;
    cmd_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_10us = 1'b1;
      @(negedge clk); tick_10us = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(RDC, v);
    check("R1 reset read", v, 32'h0);
    check("R1 reset run", {31'b0, running}, 32'h0);
  endtask

  task automatic t_start_count;
    logic [31:0] v;
    wr(WRC, 32'h8000_0000);
    rd(RDC, v);
    check("R2 start", v, 32'h8000_0000);
    ticks(5);
    repeat (4) @(negedge clk);
    rd(RDC, v);
    check("R3 five ticks", v, 32'h8000_0005);
  endtask

  task automatic t_stop_hold;
    logic [31:0] v;
    wr(WRC, 32'h0);
    ticks(3);
    rd(RDC, v);
    check("R4 stop holds", v, 32'h0000_0005);
  endtask

  task automatic t_saturate;
    logic [31:0] v;
    wr(WRC, 32'h8000_0000);
    ticks(254);
    rd(RDC, v);
    check("R5 one below limit", v, 32'h8000_00FE);
    ticks(1);
    rd(RDC, v);
    check("R5 limit stops", v, 32'h0000_00FF);
    ticks(3);
    rd(RDC, v);
    check("R5 stays at limit", v, 32'h0000_00FF);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(WRC, 32'h8000_0000);
    irq_status = 8'hF0; irq_enable = 8'h0F;
    ticks(4);
    rd(RDC, v);
    check("R6 masked status ignored", v, 32'h8000_0004);
    @(negedge clk); irq_enable = 8'h10;
    @(negedge clk); irq_status = '0; irq_enable = '0;
    ticks(2);
    rd(RDC, v);
    check("R6 enabled irq freezes", v, 32'h0000_0004);
  endtask

  task automatic t_write_vs_irq;
    logic [31:0] v;
    wr(WRC, 32'h8000_0000);
    ticks(2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = WRC; wr_data = 32'h8000_0000;
    irq_status = 8'h01; irq_enable = 8'h01;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0; irq_status = '0; irq_enable = '0;
    rd(RDC, v);
    check("R7 write wins", v, 32'h8000_0000);
    ticks(1);
    rd(RDC, v);
    check("R7 still running", v, 32'h8000_0001);
  endtask

  task automatic t_irq_vs_tick;
    logic [31:0] v;
    wr(WRC, 32'h8000_0000);
    ticks(3);
    @(negedge clk);
    tick_10us = 1'b1; irq_status = 8'h80; irq_enable = 8'h80;
    @(negedge clk);
    tick_10us = 1'b0; irq_status = '0; irq_enable = '0;
    rd(RDC, v);
    check("R8 irq beats tick", v, 32'h0000_0003);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(WRC, 32'hFF00_0000);
    ticks(2);
    rd(RDC, v);
    check("R9 reserved zero", v, 32'h8000_0002);
    wr(8'hA6, 32'h0);
    rd(RDC, v);
    check("R9 wrong write code ignored", v, 32'h8000_0002);
    rd(8'h26, v);
    check("R9 wrong read code", v, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = RDC;
    #1 v = rd_data;
    check("R9 no valid", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_count();
    t_stop_hold();
    t_saturate();
    t_irq();
    t_write_vs_irq();
    t_irq_vs_tick();
    t_decode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule